// File: doc/BRIEF.md
# H-Bridge Chopper Current Limiter with Short-Circuit Classification

This block is the digital timing core that sits between the current comparators of one H-bridge output pair and the gate drivers. Each of the two legs is commanded either high (high-side switch on) or low (low-side switch on) while a common drive request is active. When the low-side current of a leg rises over the active limit threshold, the leg first enters a blanking window. During that window the low side stays on, so that a much larger current can be recognised. If the limit comparator is still asserted when the window ends, the low side is switched off for a fixed off-time and then switched back on. This is the chopper.

A short-circuit comparator hit during blanking is a short to supply. A high-side short comparator hit while that high side is on is a short to ground. Either event opens every switch at once and starts a coincidence window. If the opposite kind of short indication arrives inside that window, the fault is reported as a short across the load instead. Each fault is reported as a single-cycle pulse that carries the leg it came from. A separate fault register is expected to consume these pulses. The switches stay open until the drive request is withdrawn. A temperature-zone input selects which of two limit comparators, nominal or reduced, is the active one. All windows are parameters counted in clock cycles.

Top module: `hb_chop_guard`

## Requirements
- R1: With `drive_en`=1 and no fault held, `hs_en[i]` equals `leg_high[i]` and `ls_en[i]` equals its inverse in the same cycle, except during an off-time. With `drive_en`=0 all enables are 0. Bit 0 is output 1 and bit 1 is output 2.
- R2: The active limit flag of leg i is `lim_hot[i]` when `hot_zone`=1 and `lim_nom[i]` when `hot_zone`=0. The flag that is not selected has no effect on the enables.
- R3: When the low side of a leg is enabled and its active limit flag is sampled high while the leg is idle, a blanking window of T_BLANK cycles starts, and `ls_en` stays high throughout it. If the limit flag is sampled low, or the low side is no longer requested, during the window, the leg returns to idle with no off-time and no fault.
- R4: If the limit flag is still high at the last blanking cycle, `ls_en` goes low for exactly T_OFF cycles and then returns high.
- R5: A low-side short flag sampled during blanking is a short-to-supply event for that leg. A low-side short flag outside blanking has no effect.
- R6: A high-side short flag sampled while that leg's `hs_en` is high is a short-to-ground event for that leg.
- R7: From the cycle after the first short event, every enable is 0. This holds through the coincidence window and afterwards, until `drive_en` is sampled low.
- R8: If an event of one kind and a raw short flag of the opposite side (any leg) occur within T_COIN clock edges of each other, or both kinds occur in the same cycle, a single `flt_load` pulse is given and no ground or supply pulse is given.
- R9: Without coincidence, `flt_gnd` or `flt_sup` pulses once, T_COIN cycles after the event. Every fault pulse is one cycle wide, at most one kind pulses per shutdown, and `flt_leg` gives the leg of the first event (leg 0 wins a tie). `flt_leg` is 0 when no pulse is present.
- R10: After synchronous reset, all legs are idle, no fault is held and all fault outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| drive_en | input | 1 | Bridge drive request; low releases a held fault |
| leg_high | input | 2 | Per leg: 1 = high side on, 0 = low side on |
| hot_zone | input | 1 | Selects the reduced limit comparator |
| lim_nom | input | 2 | Low-side current over nominal limit, per leg |
| lim_hot | input | 2 | Low-side current over reduced limit, per leg |
| hs_short | input | 2 | High-side current over short threshold, per leg |
| ls_short | input | 2 | Low-side current over short threshold, per leg |
| hs_en | output | 2 | High-side switch enables |
| ls_en | output | 2 | Low-side switch enables |
| flt_gnd | output | 1 | Short-to-ground pulse |
| flt_sup | output | 1 | Short-to-supply pulse |
| flt_load | output | 1 | Short-across-load pulse |
| flt_leg | output | 1 | Leg of the reported fault |

## Verification
Short limit excursions that drop inside blanking are mixed with limit flags held long enough to chop repeatedly. This separates the release path from the off-time path. Each limit flag is driven with the zone input in both settings, which shows that only the selected comparator acts. Short flags are applied inside blanking, outside blanking, on either leg, alone, in the same cycle and a few cycles apart. These cases tell supply, ground and load classification apart and show that the faulting leg is reported. After each fault the drive request is held and then dropped, to show the hold and the release.

// File: rtl/cl_pkg.sv
package cl_pkg;

    localparam int NUM_LEGS = 2;

    typedef enum logic [1:0] {
        LEG_IDLE  = 2'd0,
        LEG_BLANK = 2'd1,
        LEG_OFF   = 2'd2
    } leg_mode_e;

    typedef enum logic [1:0] {
        CL_CLEAR  = 2'd0,
        CL_WINDOW = 2'd1,
        CL_HOLD   = 2'd2
    } cls_state_e;

    typedef enum logic {
        SK_GND = 1'b0,
        SK_SUP = 1'b1
    } short_kind_e;

    typedef struct packed {
        logic gnd;
        logic sup;
        logic load;
        logic leg;
    } fault_pulse_t;

    function automatic logic pick_limit(input logic hot, input logic nom_flag, input logic hot_flag);
        return hot ? hot_flag : nom_flag;
    endfunction

    function automatic logic first_leg(input logic [NUM_LEGS-1:0] v);
        return v[0] ? 1'b0 : 1'b1;
    endfunction

endpackage

// File: rtl/chop_leg.sv
module chop_leg
    import cl_pkg::*;
#(
    parameter int T_BLANK = 4,
    parameter int T_OFF   = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic leg_high,
    input  logic hot_zone,
    input  logic lim_nom,
    input  logic lim_hot,
    input  logic hs_short,
    input  logic ls_short,
    output logic hs_en,
    output logic ls_en,
    output logic scg_evt,
    output logic scb_evt
);
    localparam int TMAX = (T_BLANK > T_OFF) ? T_BLANK : T_OFF;
    localparam int CW   = $clog2(TMAX + 1);

    leg_mode_e mode;
    logic [CW-1:0] cnt;
    logic lim_act;
    logic ls_path;

    assign lim_act = pick_limit(hot_zone, lim_nom, lim_hot);
    assign ls_path = run & ~leg_high;
    assign hs_en   = run & leg_high;
    assign ls_en   = ls_path & (mode != LEG_OFF);
    assign scg_evt = hs_en & hs_short;
    assign scb_evt = ls_path & (mode == LEG_BLANK) & ls_short;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode <= LEG_IDLE;
            cnt  <= '0;
        end else begin
            case (mode)
                LEG_IDLE: begin
                    if (ls_path && lim_act) begin
                        mode <= LEG_BLANK;
                        cnt  <= '0;
                    end
                end
                LEG_BLANK: begin
                    if (!ls_path || !lim_act) begin
                        mode <= LEG_IDLE;
                    end else if (cnt == CW'(T_BLANK - 1)) begin
                        mode <= LEG_OFF;
                        cnt  <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                LEG_OFF: begin
                    if (cnt == CW'(T_OFF - 1)) begin
                        mode <= LEG_IDLE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: mode <= LEG_IDLE;
            endcase
        end
    end

    // R4: a limit still present at the end of blanking opens the low side
    a_r4_chop_after_blank: assert property (@(posedge clk) disable iff (rst)
        (mode == LEG_BLANK && cnt == CW'(T_BLANK - 1) && ls_path && lim_act) |=> !ls_en);

    // R3: a limit that falls inside blanking releases without off-time
    a_r3_release_no_off: assert property (@(posedge clk) disable iff (rst)
        (mode == LEG_BLANK && !lim_act) |=> (mode == LEG_IDLE));

    // R4: the off-time counter never passes its limit
    a_r4_off_bounded: assert property (@(posedge clk) disable iff (rst)
        (mode == LEG_OFF) |-> (cnt < CW'(T_OFF)));

endmodule

// File: rtl/short_classifier.sv
module short_classifier
    import cl_pkg::*;
#(
    parameter int T_COIN = 6
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                drive_en,
    input  logic [NUM_LEGS-1:0] scg_evt,
    input  logic [NUM_LEGS-1:0] scb_evt,
    input  logic                hs_short_any,
    input  logic                ls_short_any,
    output logic                shut,
    output fault_pulse_t        pulse
);
    localparam int CCW = $clog2(T_COIN + 1);

    cls_state_e    st;
    short_kind_e   kind;
    logic          src_leg;
    logic [CCW-1:0] cnt;
    logic          any_gnd;
    logic          any_sup;
    logic          opposite;

    assign any_gnd  = |scg_evt;
    assign any_sup  = |scb_evt;
    assign opposite = (kind == SK_GND) ? ls_short_any : hs_short_any;
    assign shut     = (st != CL_CLEAR);

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= CL_CLEAR;
            kind    <= SK_GND;
            src_leg <= 1'b0;
            cnt     <= '0;
            pulse   <= '0;
        end else begin
            pulse <= '0;
            case (st)
                CL_CLEAR: begin
                    if (any_gnd && any_sup) begin
                        st         <= CL_HOLD;
                        pulse.load <= 1'b1;
                        pulse.leg  <= first_leg(scg_evt | scb_evt);
                    end else if (any_gnd || any_sup) begin
                        st      <= CL_WINDOW;
                        kind    <= any_gnd ? SK_GND : SK_SUP;
                        src_leg <= first_leg(scg_evt | scb_evt);
                        cnt     <= '0;
                    end
                end
                CL_WINDOW: begin
                    if (opposite) begin
                        st         <= CL_HOLD;
                        pulse.load <= 1'b1;
                        pulse.leg  <= src_leg;
                    end else if (cnt == CCW'(T_COIN - 1)) begin
                        st        <= CL_HOLD;
                        pulse.gnd <= (kind == SK_GND);
                        pulse.sup <= (kind == SK_SUP);
                        pulse.leg <= src_leg;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                CL_HOLD: begin
                    if (!drive_en) st <= CL_CLEAR;
                end
                default: st <= CL_CLEAR;
            endcase
        end
    end

    // R9: never more than one fault kind at a time
    a_r9_one_kind: assert property (@(posedge clk) disable iff (rst)
        $onehot0({pulse.gnd, pulse.sup, pulse.load}));

    // R9: every fault pulse lasts one cycle
    a_r9_single_cycle: assert property (@(posedge clk) disable iff (rst)
        (pulse.gnd || pulse.sup || pulse.load) |=> !(pulse.gnd || pulse.sup || pulse.load));

    // R7: a first short event leads to shutdown on the next cycle
    a_r7_event_shuts: assert property (@(posedge clk) disable iff (rst)
        (st == CL_CLEAR && (any_gnd || any_sup)) |=> shut);

endmodule

// File: rtl/hb_chop_guard.sv
module hb_chop_guard
    import cl_pkg::*;
#(
    parameter int T_BLANK = 4,
    parameter int T_OFF   = 8,
    parameter int T_COIN  = 6
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       drive_en,
    input  logic [1:0] leg_high,
    input  logic       hot_zone,
    input  logic [1:0] lim_nom,
    input  logic [1:0] lim_hot,
    input  logic [1:0] hs_short,
    input  logic [1:0] ls_short,
    output logic [1:0] hs_en,
    output logic [1:0] ls_en,
    output logic       flt_gnd,
    output logic       flt_sup,
    output logic       flt_load,
    output logic       flt_leg
);
    logic                shut;
    logic                run;
    logic [NUM_LEGS-1:0] scg_evt;
    logic [NUM_LEGS-1:0] scb_evt;
    fault_pulse_t        pulse;

    assign run = drive_en & ~shut;

    for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
        chop_leg #(.T_BLANK(T_BLANK), .T_OFF(T_OFF)) i_leg (
            .clk      (clk),
            .rst      (rst),
            .run      (run),
            .leg_high (leg_high[g]),
            .hot_zone (hot_zone),
            .lim_nom  (lim_nom[g]),
            .lim_hot  (lim_hot[g]),
            .hs_short (hs_short[g]),
            .ls_short (ls_short[g]),
            .hs_en    (hs_en[g]),
            .ls_en    (ls_en[g]),
            .scg_evt  (scg_evt[g]),
            .scb_evt  (scb_evt[g])
        );
    end

    short_classifier #(.T_COIN(T_COIN)) i_cls (
        .clk          (clk),
        .rst          (rst),
        .drive_en     (drive_en),
        .scg_evt      (scg_evt),
        .scb_evt      (scb_evt),
        .hs_short_any (|hs_short),
        .ls_short_any (|ls_short),
        .shut         (shut),
        .pulse        (pulse)
    );

    assign flt_gnd  = pulse.gnd;
    assign flt_sup  = pulse.sup;
    assign flt_load = pulse.load;
    assign flt_leg  = pulse.leg;

    // R7: a held fault keeps every switch open
    a_r7_all_off: assert property (@(posedge clk) disable iff (rst)
        shut |-> (hs_en == 2'b00 && ls_en == 2'b00));

    // R10: fault outputs are quiet in the cycle after reset
    a_r10_quiet_after_reset: assert property (@(posedge clk)
        $past(rst) |-> !(flt_gnd || flt_sup || flt_load));

endmodule

// File: tb/test_hb_chop_guard.sv
`timescale 1ns/1ps
module test_hb_chop_guard;
    localparam int TB_BLANK = 4;
    localparam int TB_OFF   = 8;
    localparam int TB_COIN  = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic drive_en = 1'b0;
    logic [1:0] leg_high = 2'b00;
    logic hot_zone = 1'b0;
    logic [1:0] lim_nom = 2'b00;
    logic [1:0] lim_hot = 2'b00;
    logic [1:0] hs_short = 2'b00;
    logic [1:0] ls_short = 2'b00;
    logic [1:0] hs_en, ls_en;
    logic flt_gnd, flt_sup, flt_load, flt_leg;

    int compared = 0;
    int mismatched = 0;
    string tag = "R10";

    // reference model state
    int md [2];
    int mc [2];
    int cst = 0;
    int ckind = 0;
    int cid = 0;
    int ccnt = 0;
    int e_gnd = 0, e_sup = 0, e_load = 0, e_leg = 0;

    always #10 clk = ~clk;

    hb_chop_guard #(.T_BLANK(TB_BLANK), .T_OFF(TB_OFF), .T_COIN(TB_COIN)) i_hb_chop_guard (
        .clk(clk), .rst(rst), .drive_en(drive_en), .leg_high(leg_high),
        .hot_zone(hot_zone), .lim_nom(lim_nom), .lim_hot(lim_hot),
        .hs_short(hs_short), .ls_short(ls_short), .hs_en(hs_en), .ls_en(ls_en),
        .flt_gnd(flt_gnd), .flt_sup(flt_sup), .flt_load(flt_load), .flt_leg(flt_leg)
    );

    task automatic check_now();
        logic [1:0] ehs, els;
        bit erun;
        erun = drive_en && (cst == 0);
        for (int i = 0; i < 2; i++) begin
            ehs[i] = erun && leg_high[i];
            els[i] = erun && !leg_high[i] && (md[i] != 2);
        end
        compared++;
        if (hs_en !== ehs || ls_en !== els || flt_gnd !== e_gnd[0] || flt_sup !== e_sup[0]
            || flt_load !== e_load[0] || flt_leg !== e_leg[0]) begin
            mismatched++;
            $display("FAIL %s t=%0t: hs=%b ls=%b g=%b s=%b l=%b leg=%b expected hs=%b ls=%b g=%0d s=%0d l=%0d leg=%0d",
                     tag, $time, hs_en, ls_en, flt_gnd, flt_sup, flt_load, flt_leg,
                     ehs, els, e_gnd, e_sup, e_load, e_leg);
        end
    endtask

    task automatic advance();
        bit run;
        bit lim, lsp, hsn;
        bit [1:0] g, s;
        if (rst) begin
            for (int i = 0; i < 2; i++) begin md[i] = 0; mc[i] = 0; end
            cst = 0; ckind = 0; cid = 0; ccnt = 0;
            e_gnd = 0; e_sup = 0; e_load = 0; e_leg = 0;
            return;
        end
        run = drive_en && (cst == 0);
        for (int i = 0; i < 2; i++) begin
            lim = hot_zone ? lim_hot[i] : lim_nom[i];
            lsp = run && !leg_high[i];
            hsn = run && leg_high[i];
            g[i] = hsn && hs_short[i];
            s[i] = lsp && (md[i] == 1) && ls_short[i];
            if (md[i] == 0) begin
                if (lsp && lim) begin md[i] = 1; mc[i] = 0; end
            end else if (md[i] == 1) begin
                if (!lsp || !lim) md[i] = 0;
                else if (mc[i] == TB_BLANK - 1) begin md[i] = 2; mc[i] = 0; end
                else mc[i]++;
            end else begin
                if (mc[i] == TB_OFF - 1) md[i] = 0;
                else mc[i]++;
            end
        end
        e_gnd = 0; e_sup = 0; e_load = 0; e_leg = 0;
        if (cst == 0) begin
            if (g != 0 && s != 0) begin
                e_load = 1; e_leg = (g[0] || s[0]) ? 0 : 1; cst = 2;
            end else if (g != 0 || s != 0) begin
                ckind = (g != 0) ? 0 : 1;
                cid = (g[0] || s[0]) ? 0 : 1;
                ccnt = 0; cst = 1;
            end
        end else if (cst == 1) begin
            if ((ckind == 0 && ls_short != 0) || (ckind == 1 && hs_short != 0)) begin
                e_load = 1; e_leg = cid; cst = 2;
            end else if (ccnt == TB_COIN - 1) begin
                if (ckind == 0) e_gnd = 1; else e_sup = 1;
                e_leg = cid; cst = 2;
            end else ccnt++;
        end else begin
            if (!drive_en) cst = 0;
        end
    endtask

    task automatic cyc(input int n);
        for (int k = 0; k < n; k++) begin
            #1;
            check_now();
            advance();
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic release_fault();
        drive_en = 1'b0;
        hs_short = 2'b00; ls_short = 2'b00; lim_nom = 2'b00; lim_hot = 2'b00;
        cyc(3);
        drive_en = 1'b1;
        cyc(2);
    endtask

    initial begin
        #(20 * 100000);
        mismatched++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        for (int i = 0; i < 2; i++) begin md[i] = 0; mc[i] = 0; end
        @(negedge clk);
        // R10: reset state
        tag = "R10"; rst = 1'b1; cyc(3);
        rst = 1'b0; cyc(2);

        // R1: direction control and drive request
        tag = "R1"; drive_en = 1'b1;
        leg_high = 2'b01; cyc(3);
        leg_high = 2'b10; cyc(3);
        drive_en = 1'b0; cyc(2);
        drive_en = 1'b1; leg_high = 2'b00; cyc(2);

        // R3: limit excursion shorter than blanking, no off-time
        tag = "R3"; lim_nom = 2'b01; cyc(2); lim_nom = 2'b00; cyc(6);
        // R3: low side withdrawn during blanking
        lim_nom = 2'b10; cyc(2); leg_high = 2'b10; cyc(2); lim_nom = 2'b00; leg_high = 2'b00; cyc(4);

        // R4: limit held, repeated chop cycles on both legs
        tag = "R4"; lim_nom = 2'b11; cyc(30); lim_nom = 2'b00; cyc(12);

        // R2: reduced threshold selected; nominal flag must be ignored
        tag = "R2"; hot_zone = 1'b1; lim_nom = 2'b11; cyc(10);
        lim_nom = 2'b00; lim_hot = 2'b01; cyc(16); lim_hot = 2'b00; cyc(10);
        hot_zone = 1'b0; lim_hot = 2'b10; cyc(6); lim_hot = 2'b00; cyc(2);

        // R5: low-side short outside blanking has no effect
        tag = "R5"; ls_short = 2'b11; cyc(3); ls_short = 2'b00; cyc(2);
        // R5: short to supply on leg 1 during blanking
        lim_nom = 2'b10; cyc(2); ls_short = 2'b10; cyc(1); ls_short = 2'b00; cyc(TB_COIN + 3);
        // R7: fault held while drive request stays high
        tag = "R7"; cyc(5); release_fault();

        // R6: short to ground on leg 0 with its high side on
        tag = "R6"; leg_high = 2'b01; cyc(2); hs_short = 2'b01; cyc(1); hs_short = 2'b00;
        cyc(TB_COIN + 3); release_fault();
        // R6: high-side short flag while low side on is ignored
        leg_high = 2'b00; hs_short = 2'b11; cyc(3); hs_short = 2'b00; cyc(2);

        // R8: ground event then low-side short three cycles later
        tag = "R8"; leg_high = 2'b10; cyc(1); hs_short = 2'b10; cyc(1); hs_short = 2'b00;
        cyc(2); ls_short = 2'b01; cyc(1); ls_short = 2'b00; cyc(4); release_fault();
        // R8: supply event on leg 0 and ground event on leg 1 in the same cycle
        leg_high = 2'b10; lim_nom = 2'b01; cyc(2); ls_short = 2'b01; hs_short = 2'b10; cyc(1);
        ls_short = 2'b00; hs_short = 2'b00; lim_nom = 2'b00; cyc(4); release_fault();
        // R9: opposite flag one edge after the window closes gives a plain ground pulse
        tag = "R9"; leg_high = 2'b11; cyc(1); hs_short = 2'b10; cyc(1); hs_short = 2'b00;
        cyc(TB_COIN); ls_short = 2'b01; cyc(1); ls_short = 2'b00; cyc(3); release_fault();
        // R9: simultaneous ground events on both legs report leg 0
        hs_short = 2'b11; cyc(1); hs_short = 2'b00; cyc(TB_COIN + 2); release_fault();

        // R10: reset in the middle of a fault window
        tag = "R10"; leg_high = 2'b01; hs_short = 2'b01; cyc(1); hs_short = 2'b00; cyc(2);
        rst = 1'b1; cyc(2); rst = 1'b0; cyc(4);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule